// File: doc/BRIEF.md
# Power Mode and Reset Controller

This block decides when the core of a small microcontroller runs, idles or sleeps. It holds the power-control register, which the core writes through a byte-wide register port, and turns the requests in it into a clock-gate enable for the core and an oscillator shutdown request. It also brings out the ALE-disable and baud-doubling controls kept in the same register.

A noisy external reset pin is only trusted after it has been seen high for a run of consecutive clock cycles. The block synchronises the pin, counts the run, and drives a synchronous core reset for as long as the pin stays high. Waking from idle needs any enabled interrupt. Waking from power-down needs one of the wake sources that the register itself enables. The wake-up timer counts as a source only when the oscillator is kept running.

Top module: `pwrmode_ctrl`

## Requirements
- R1: After two synchroniser stages, `core_rst` goes high once `rst_pin` has been sampled high on 16 consecutive clock edges. With the pin driven high just after an edge, that is the 18th edge that follows, and `core_rst` stays high while the pin stays high.
- R2: If `rst_pin` is sampled low before the count reaches 16, the count starts again from zero. A later high run must again last the full 16 samples.
- R3: `core_rst` falls on the third edge after the pin goes low. While `core_rst` is high, the control register is cleared to 00h and the block returns to the run state with `core_clk_en` high. The asynchronous `rst_n` gives the same state: register 00h, run, no oscillator request.
- R4: A register write stores the whole byte, read back on `pwr_ctl_q`. Bit 0 is the idle request and bit 1 the power-down request. Bits 2 and 3 are free flags. Bit 4 drives `ale_dis`, bit 5 enables the external-interrupt wake, bit 6 enables the SPI wake, and bit 7 drives `baud_dbl`.
- R5: When bit 0 is set while running, `core_clk_en` is low from the next edge (idle).
- R6: Idle ends on the edge where `irq_any` is high. That edge clears bit 0 and sets `core_clk_en` high. Wake lines without `irq_any` do not end idle.
- R7: When bit 1 is set while running, the block enters power-down on the next edge. If bits 0 and 1 are both set, power-down wins.
- R8: In power-down, `wake_int0` wakes the block only if bit 5 is set, and `wake_spi` only if bit 6 is set. A wake clears bit 1 and leaves all other bits as they were.
- R9: `wake_tic` wakes the block from power-down only while `osc_off_cfg` is low.
- R10: `osc_pd_req` is high only in power-down, and only while `osc_off_cfg` is high.
- R11: `irq_any` has no effect in power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core-domain clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| rst_pin | input | 1 | Raw external reset pin, active high |
| pwr_ctl_we | input | 1 | Write strobe for the power-control register |
| pwr_ctl_wdata | input | 8 | Write data |
| irq_any | input | 1 | Some enabled interrupt is pending |
| wake_int0 | input | 1 | External interrupt 0 wake event |
| wake_spi | input | 1 | SPI interrupt wake event |
| wake_tic | input | 1 | Wake-up timer event |
| osc_off_cfg | input | 1 | Clock-control setting: stop the oscillator in power-down |
| pwr_ctl_q | output | 8 | Current register value |
| core_rst | output | 1 | Synchronous core reset |
| core_clk_en | output | 1 | Core clock-gate enable |
| osc_pd_req | output | 1 | Request to power down the oscillator |
| ale_dis | output | 1 | Disable the address-latch strobe |
| baud_dbl | output | 1 | Double the UART baud rate |

## Verification
The hardest case to reach is a reset-pin run that is cut short just before it qualifies and then restarts. The bench must show that the second run must be a full 16 samples long, not the remainder of the first run. It holds the pin high for ten cycles, drops it for two, raises it again, and samples `core_rst` on the 17th and 18th edges after the restart. A second hard case is a power-down with no valid wake source, where nothing the core can do brings the block back. There the bench leaves power-down by qualifying a pin reset, which checks R1 and R3 from inside sleep.

// File: rtl/pwr_pkg.sv
`timescale 1ns/1ps
package pwr_pkg;
  typedef enum logic [1:0] {
    PM_RUN  = 2'd0,
    PM_IDLE = 2'd1,
    PM_DOWN = 2'd2
  } pm_state_t;

  localparam int CTL_W      = 8;
  localparam int B_IDLE     = 0;
  localparam int B_DOWN     = 1;
  localparam int B_ALE_OFF  = 4;
  localparam int B_WK_INT0  = 5;
  localparam int B_WK_SPI   = 6;
  localparam int B_BAUD_X2  = 7;
endpackage

// File: rtl/rst_pin_qual.sv
`timescale 1ns/1ps
module rst_pin_qual #(
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CYC    = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_raw,
  output logic qualified
);
  localparam int CW = $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] HOLD_V = CW'(HOLD_CYC);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          run_q, run_d;

  // synchroniser chain
  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[0] <= 1'b0;
          else        sync_q[0] <= pin_raw;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[s] <= 1'b0;
          else        sync_q[s] <= sync_q[s-1];
        end
      end
    end
  endgenerate

  // run-length counter: saturates at HOLD, restarts on any low sample
  always_comb begin
    run_d = run_q;
    if (!sync_q[SYNC_STAGES-1])  run_d = '0;
    else if (run_q != HOLD_V)    run_d = run_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_d;
  end

  assign qualified = (run_q == HOLD_V);
endmodule

// File: rtl/pwr_ctl_reg.sv
`timescale 1ns/1ps
module pwr_ctl_reg
  import pwr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sys_rst,
  input  logic             we,
  input  logic [CTL_W-1:0] wdata,
  input  logic             clr_idle,
  input  logic             clr_down,
  output logic [CTL_W-1:0] q
);
  logic [CTL_W-1:0] q_d;
  logic             q_en;

  always_comb begin
    q_d  = q;
    q_en = 1'b0;
    if (sys_rst) begin
      q_d  = '0;
      q_en = 1'b1;
    end else if (clr_idle || clr_down) begin
      q_d[B_IDLE] = q[B_IDLE] & ~clr_idle;
      q_d[B_DOWN] = q[B_DOWN] & ~clr_down;
      q_en        = 1'b1;
    end else if (we) begin
      q_d  = wdata;
      q_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (q_en) q <= q_d;
  end
endmodule

// File: rtl/pm_fsm.sv
`timescale 1ns/1ps
module pm_fsm
  import pwr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sys_rst,
  input  logic      req_idle,
  input  logic      req_down,
  input  logic      en_int0,
  input  logic      en_spi,
  input  logic      irq_any,
  input  logic      wake_int0,
  input  logic      wake_spi,
  input  logic      wake_tic,
  input  logic      osc_off_cfg,
  output pm_state_t st,
  output logic      clr_idle,
  output logic      clr_down
);
  pm_state_t st_d;
  logic      down_wake;

  assign down_wake = (en_int0 & wake_int0)
                   | (en_spi  & wake_spi)
                   | (wake_tic & ~osc_off_cfg);

  always_comb begin
    st_d     = st;
    clr_idle = 1'b0;
    clr_down = 1'b0;
    if (sys_rst) begin
      st_d = PM_RUN;
    end else begin
      unique case (st)
        PM_RUN: begin
          if (req_down)      st_d = PM_DOWN;
          else if (req_idle) st_d = PM_IDLE;
        end
        PM_IDLE: begin
          if (irq_any) begin
            st_d     = PM_RUN;
            clr_idle = 1'b1;
          end
        end
        PM_DOWN: begin
          if (down_wake) begin
            st_d     = PM_RUN;
            clr_down = 1'b1;
          end
        end
        default: st_d = PM_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= PM_RUN;
    else        st <= st_d;
  end
endmodule

// File: rtl/pwrmode_ctrl.sv
`timescale 1ns/1ps
module pwrmode_ctrl
  import pwr_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CYC    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rst_pin,
  input  logic             pwr_ctl_we,
  input  logic [CTL_W-1:0] pwr_ctl_wdata,
  input  logic             irq_any,
  input  logic             wake_int0,
  input  logic             wake_spi,
  input  logic             wake_tic,
  input  logic             osc_off_cfg,
  output logic [CTL_W-1:0] pwr_ctl_q,
  output logic             core_rst,
  output logic             core_clk_en,
  output logic             osc_pd_req,
  output logic             ale_dis,
  output logic             baud_dbl
);
  pm_state_t st;
  logic      clr_idle, clr_down;

  rst_pin_qual #(.SYNC_STAGES(SYNC_STAGES), .HOLD_CYC(HOLD_CYC)) u_qual (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_raw   (rst_pin),
    .qualified (core_rst)
  );

  pwr_ctl_reg u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .sys_rst  (core_rst),
    .we       (pwr_ctl_we),
    .wdata    (pwr_ctl_wdata),
    .clr_idle (clr_idle),
    .clr_down (clr_down),
    .q        (pwr_ctl_q)
  );

  pm_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .sys_rst     (core_rst),
    .req_idle    (pwr_ctl_q[B_IDLE]),
    .req_down    (pwr_ctl_q[B_DOWN]),
    .en_int0     (pwr_ctl_q[B_WK_INT0]),
    .en_spi      (pwr_ctl_q[B_WK_SPI]),
    .irq_any     (irq_any),
    .wake_int0   (wake_int0),
    .wake_spi    (wake_spi),
    .wake_tic    (wake_tic),
    .osc_off_cfg (osc_off_cfg),
    .st          (st),
    .clr_idle    (clr_idle),
    .clr_down    (clr_down)
  );

  assign core_clk_en = (st == PM_RUN);
  assign osc_pd_req  = (st == PM_DOWN) & osc_off_cfg;
  assign ale_dis     = pwr_ctl_q[B_ALE_OFF];
  assign baud_dbl    = pwr_ctl_q[B_BAUD_X2];
endmodule

// File: rtl/pm_chk.sv
`timescale 1ns/1ps
module pm_chk
  import pwr_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input pm_state_t        st,
  input logic             core_rst,
  input logic [CTL_W-1:0] pwr_ctl_q,
  input logic             pwr_ctl_we,
  input logic             irq_any,
  input logic             wake_int0,
  input logic             wake_spi,
  input logic             wake_tic,
  input logic             osc_off_cfg,
  input logic             osc_pd_req
);
  // R3
  rst_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst |=> (pwr_ctl_q == '0 && st == PM_RUN));

  // R5
  idle_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PM_RUN && !core_rst && pwr_ctl_q[B_IDLE] && !pwr_ctl_q[B_DOWN])
      |=> st == PM_IDLE);

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PM_IDLE && !core_rst && !irq_any) |=> st == PM_IDLE);

  // R8
  down_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PM_DOWN && !core_rst
     && !(pwr_ctl_q[B_WK_INT0] && wake_int0)
     && !(pwr_ctl_q[B_WK_SPI] && wake_spi)
     && !(wake_tic && !osc_off_cfg)) |=> st == PM_DOWN);

  // R8
  down_exit_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PM_RUN && $past(st) == PM_DOWN && !$past(pwr_ctl_we))
      |-> !pwr_ctl_q[B_DOWN]);

  // R10
  osc_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    osc_pd_req |-> (st == PM_DOWN && osc_off_cfg));
endmodule

bind pwrmode_ctrl pm_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .st          (st),
  .core_rst    (core_rst),
  .pwr_ctl_q   (pwr_ctl_q),
  .pwr_ctl_we  (pwr_ctl_we),
  .irq_any     (irq_any),
  .wake_int0   (wake_int0),
  .wake_spi    (wake_spi),
  .wake_tic    (wake_tic),
  .osc_off_cfg (osc_off_cfg),
  .osc_pd_req  (osc_pd_req)
);

// File: tb/tb_pwrmode_ctrl.sv
`timescale 1ns/1ps
module tb_pwrmode_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       rst_pin;
  logic       we;
  logic [7:0] wdata;
  logic       irq_any, wake_int0, wake_spi, wake_tic, osc_off_cfg;
  logic [7:0] pq;
  logic       core_rst, core_clk_en, osc_pd_req, ale_dis, baud_dbl;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  pwrmode_ctrl dut (
    .clk(clk), .rst_n(rst_n), .rst_pin(rst_pin),
    .pwr_ctl_we(we), .pwr_ctl_wdata(wdata),
    .irq_any(irq_any), .wake_int0(wake_int0), .wake_spi(wake_spi),
    .wake_tic(wake_tic), .osc_off_cfg(osc_off_cfg),
    .pwr_ctl_q(pq), .core_rst(core_rst), .core_clk_en(core_clk_en),
    .osc_pd_req(osc_pd_req), .ale_dis(ale_dis), .baud_dbl(baud_dbl)
  );

  // {ctl[13:6], osc_off[5], irq[4], int0[3], spi[2], tic[1], expect_wake[0]}
  localparam logic [13:0] VEC [8] = '{
    {8'h22, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},  // R8 int0 enabled
    {8'h02, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},  // R8 int0 not enabled
    {8'h42, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},  // R8 spi enabled
    {8'h22, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},  // R8 spi not enabled
    {8'h0E, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},  // R9 timer, osc kept
    {8'h02, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},  // R9 timer, osc stopped
    {8'h03, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},  // R7/R11 both bits, irq
    {8'hE2, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1}   // R8 both enabled
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_ctl(input logic [7:0] v);
    we = 1'b1; wdata = v;
    @(negedge clk);
    we = 1'b0;
  endtask

  // R1 R3: qualify a pin reset from the current state
  task automatic pin_reset();
    rst_pin = 1'b1;
    repeat (17) @(negedge clk);
    chk("R1 no reset after 17 edges", {7'd0, core_rst}, 8'd0);
    @(negedge clk);
    chk("R1 reset on 18th edge", {7'd0, core_rst}, 8'd1);
    @(negedge clk);
    chk("R3 register cleared", pq, 8'h00);
    chk("R3 clock enabled", {7'd0, core_clk_en}, 8'd1);
    rst_pin = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R3 reset held 2 edges after pin low", {7'd0, core_rst}, 8'd1);
    @(negedge clk);
    chk("R3 reset released", {7'd0, core_rst}, 8'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rst_pin = 1'b0; we = 1'b0; wdata = '0;
    irq_any = 0; wake_int0 = 0; wake_spi = 0; wake_tic = 0; osc_off_cfg = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R3 reset register", pq, 8'h00);
    chk("R3 reset run", {7'd0, core_clk_en}, 8'd1);
    chk("R3 reset core_rst", {7'd0, core_rst}, 8'd0);
    chk("R10 reset osc req", {7'd0, osc_pd_req}, 8'd0);

    // R4 field mapping
    write_ctl(8'h9C);
    chk("R4 readback", pq, 8'h9C);
    chk("R4 ale_dis", {7'd0, ale_dis}, 8'd1);
    chk("R4 baud_dbl", {7'd0, baud_dbl}, 8'd1);
    @(negedge clk);
    chk("R4 flags keep run", {7'd0, core_clk_en}, 8'd1);

    // R5 R6 idle
    write_ctl(8'h1D);
    @(negedge clk);
    chk("R5 idle entered", {7'd0, core_clk_en}, 8'd0);
    wake_int0 = 1; wake_spi = 1; wake_tic = 1;
    @(negedge clk);
    wake_int0 = 0; wake_spi = 0; wake_tic = 0;
    chk("R6 wake lines ignored in idle", {7'd0, core_clk_en}, 8'd0);
    irq_any = 1;
    @(negedge clk);
    irq_any = 0;
    chk("R6 irq ends idle", {7'd0, core_clk_en}, 8'd1);
    chk("R6 idle bit cleared", pq, 8'h1C);

    // vector table: power-down wake sources
    for (int i = 0; i < 8; i++) begin
      logic [13:0] v;
      v = VEC[i];
      osc_off_cfg = v[5];
      write_ctl(v[13:6]);
      @(negedge clk);
      chk("R7 power-down entered", {7'd0, core_clk_en}, 8'd0);
      chk("R10 osc request in power-down", {7'd0, osc_pd_req}, {7'd0, v[5]});
      irq_any = v[4]; wake_int0 = v[3]; wake_spi = v[2]; wake_tic = v[1];
      @(negedge clk);
      irq_any = 0; wake_int0 = 0; wake_spi = 0; wake_tic = 0;
      chk("R8 R9 R11 wake decision", {7'd0, core_clk_en}, {7'd0, v[0]});
      chk("R8 register after event", pq, v[0] ? (v[13:6] & 8'hFD) : v[13:6]);
      if (!v[0]) pin_reset();
      else begin
        write_ctl(8'h00);
      end
      osc_off_cfg = 0;
    end

    // R2 interrupted pin run
    rst_pin = 1'b1;
    repeat (10) @(negedge clk);
    rst_pin = 1'b0;
    repeat (2) @(negedge clk);
    rst_pin = 1'b1;
    repeat (17) @(negedge clk);
    chk("R2 restarted count not yet qualified", {7'd0, core_rst}, 8'd0);
    @(negedge clk);
    chk("R2 qualified after full restart", {7'd0, core_rst}, 8'd1);
    rst_pin = 1'b0;
    repeat (3) @(negedge clk);
    chk("R2 released", {7'd0, core_rst}, 8'd0);

    // R3 reset from idle with flags set
    write_ctl(8'hBD);
    @(negedge clk);
    chk("R5 idle before reset", {7'd0, core_clk_en}, 8'd0);
    pin_reset();
    chk("R3 ale cleared", {7'd0, ale_dis}, 8'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule